// File: doc/BRIEF.md
# Battery Backup Path Controller

This block is the digital supervisor of a battery backup power path. It watches a set of comparator results (supply present, input-rail undervoltage, output-rail undervoltage, battery below its discharge cutoff, battery above its retention minimum) and decides whether the protected load is fed from the main supply, fed from the battery, or whether the block drops into micropower shutdown. It drives enables for the input ideal-diode switch, the battery ideal-diode switch and the flyback charger. It never closes both path switches at once, and it always leaves one idle cycle between opening one switch and closing the other.

When the battery sags below its cutoff while backing up the load, the battery is disconnected at once and a sticky backup-fault bit is set. The block then feeds the load from the input rail if that rail is healthy, without reconnecting the battery until the supply-present signal returns. If the input rail is also down, the block enters shutdown, and it leaves shutdown by itself when the input rail recovers. The fault bit survives loss and return of the input rail. It is cleared by the shutdown pin, by a power-on-reset write strobe, by a fault-reset write strobe, or when the battery falls below its retention minimum. An active-low supply-present status output is provided; its assertion is delayed by a parameterised number of clock cycles, while its release is not delayed.

Top module: `bkup_path_ctrl`

## Requirements
- R1: Backup is entered when the synchronized supply-present input is 0, or either undervoltage input (input rail or output rail) is 1. In backup, bat_sw_en=1, in_sw_en=0 and flyback_en=0.
- R2: When supply-present is 1 and both undervoltage inputs are 0, the block settles with in_sw_en=1, bat_sw_en=0 and flyback_en=1.
- R3: in_sw_en and bat_sw_en are never 1 in the same cycle. On every changeover between them there is exactly one cycle with both at 0.
- R4: While in backup, a battery-below-cutoff input (bat_low_a=1) turns bat_sw_en off three clock edges after it is applied: two synchronizer stages plus the state register. The same edge sets bkup_fault.
- R5: After a cutoff with the input rail healthy (dcin_uv_a=0), one idle cycle follows. Then in_sw_en=1 with flyback_en=0, and the battery is not reconnected until the backup condition of R1 clears, when flyback_en returns to 1.
- R6: After a cutoff with the input rail under voltage, all three enables are 0 (shutdown). Shutdown is left for main operation once dcin_uv_a returns to 0.
- R7: bkup_fault stays 1 through input-rail loss and return. It clears three edges after bat_min_ok_a goes to 0.
- R8: bkup_fault is cleared by a one-cycle por_wr or fault_rst_wr strobe (at the next edge), or three edges after shdn_a goes to 1.
- R9: bkfault_n is 0 exactly when gpio2_fault_sel=1, bkup_fault=1 and the synchronized input rail is not under voltage. Otherwise it is 1.
- R10: acp_n is 0 only while supply-present is 1 and the input rail is not under voltage. The 1-to-0 transition comes ACP_DELAY+3 edges after the condition appears (ACP_DELAY=8 by default, 0 means only the synchronizer and register latency). The 0-to-1 transition comes three edges after the condition ends.
- R11: shdn_a=1 together with dcin_uv_a=1 forces shutdown (all enables 0) from any mode.
- R12: During reset all enables are 0, acp_n=1, bkup_fault=0 and bkfault_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_ok_a | input | 1 | Supply-present comparator, asynchronous |
| dcin_uv_a | input | 1 | Input rail below undervoltage lockout, asynchronous |
| dcout_uv_a | input | 1 | Output rail below undervoltage lockout, asynchronous |
| bat_low_a | input | 1 | Battery below discharge cutoff, asynchronous |
| bat_min_ok_a | input | 1 | Battery above retention minimum, asynchronous |
| shdn_a | input | 1 | Shutdown/reset pin, active high, asynchronous |
| por_wr | input | 1 | Power-on-reset bit write strobe, one cycle |
| fault_rst_wr | input | 1 | Backup-fault reset bit write strobe, one cycle |
| gpio2_fault_sel | input | 1 | Selects backup-fault status on the status pin |
| in_sw_enable | output | 1 | Input ideal-diode switch enable |
| bat_sw_enable | output | 1 | Battery ideal-diode switch enable |
| flyback_enable | output | 1 | Flyback switcher enable |
| bkup_fault | output | 1 | Latched backup-fault bit |
| bkfault_n | output | 1 | Active-low backup-fault status (open-drain pull-down request) |
| acp_n | output | 1 | Active-low supply-present status with delayed assertion |

## Verification
The assertions assume that every comparator input holds a new value for at least the synchronizer depth plus one cycle, so that the synchronized values, and not raw glitches, drive the mode sequence. They also assume that the write strobes are synchronous single-cycle pulses. The stimulus changes inputs a quarter period after a rising edge and holds each setting for several cycles before sampling. Cutoff, fault clearing and status delays are sampled on the exact edge counts stated in the requirements.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

  typedef enum logic [2:0] {
    ST_SHUT = 3'd0,
    ST_MAIN = 3'd1,
    ST_G2B  = 3'd2,
    ST_BKUP = 3'd3,
    ST_G2M  = 3'd4,
    ST_G2H  = 3'd5,
    ST_HOLD = 3'd6
  } mode_e;

  typedef struct packed {
    logic in_sw;
    logic bat_sw;
    logic fly;
  } drv_t;

  // synchronized input vector bit positions
  localparam int IX_SUP   = 5;
  localparam int IX_DCIN  = 4;
  localparam int IX_DCOUT = 3;
  localparam int IX_BLOW  = 2;
  localparam int IX_BMIN  = 1;
  localparam int IX_SHDN  = 0;
  localparam int N_IN     = 6;

  function automatic logic need_backup(logic sup_ok, logic dcin_uv, logic dcout_uv);
    return !sup_ok || dcin_uv || dcout_uv;
  endfunction

  function automatic logic supply_present(logic sup_ok, logic dcin_uv);
    return sup_ok && !dcin_uv;
  endfunction

  function automatic drv_t decode(mode_e m);
    drv_t d;
    d = '0;
    case (m)
      ST_MAIN: begin d.in_sw = 1'b1; d.fly = 1'b1; end
      ST_HOLD: d.in_sw  = 1'b1;
      ST_BKUP: d.bat_sw = 1'b1;
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bkup_sync.sv
module bkup_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_a;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bkup_mode_fsm.sv
module bkup_mode_fsm
  import bkup_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sup_ok,
  input  logic  dcin_uv,
  input  logic  dcout_uv,
  input  logic  bat_low,
  input  logic  shdn,
  output mode_e mode,
  output drv_t  drv,
  output logic  cutoff_evt
);
  mode_e nxt;
  logic  need;
  logic  force_off;

  assign need       = need_backup(sup_ok, dcin_uv, dcout_uv);
  assign force_off  = shdn && dcin_uv;
  assign cutoff_evt = (mode == ST_BKUP) && bat_low;

  always_comb begin
    nxt = mode;
    if (force_off) begin
      nxt = ST_SHUT;
    end else begin
      case (mode)
        ST_SHUT: if (!dcin_uv) nxt = ST_MAIN;
        ST_MAIN: if (need) nxt = ST_G2B;
        ST_G2B:  nxt = ST_BKUP;
        ST_BKUP: begin
          if (bat_low)    nxt = dcin_uv ? ST_SHUT : ST_G2H;
          else if (!need) nxt = ST_G2M;
        end
        ST_G2M:  nxt = ST_MAIN;
        ST_G2H:  nxt = ST_HOLD;
        ST_HOLD: begin
          if (dcin_uv)    nxt = ST_SHUT;
          else if (!need) nxt = ST_MAIN;
        end
        default: nxt = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= ST_SHUT;
    else        mode <= nxt;
  end

  assign drv = decode(mode);

  AST_SW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv.in_sw && drv.bat_sw)); // R3
  AST_BAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv.bat_sw) |-> !$past(drv.in_sw)); // R3
  AST_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv.in_sw) |-> !$past(drv.bat_sw)); // R3
  AST_CUTOFF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff_evt |=> !drv.bat_sw); // R4
  AST_FLY_IN_BKUP: assert property (@(posedge clk) disable iff (!rst_n)
    drv.bat_sw |-> !drv.fly); // R1
  AST_SHUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_SHUT && !dcin_uv) |=> (mode == ST_MAIN)); // R6
  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (drv == '0)); // R11
endmodule

// File: rtl/bkup_fault_latch.sv
module bkup_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cutoff_evt,
  input  logic shdn,
  input  logic por_wr,
  input  logic fault_rst_wr,
  input  logic bat_min_ok,
  input  logic dcin_uv,
  input  logic gpio2_fault_sel,
  output logic fault_q,
  output logic fault_n
);
  logic clr_any;

  assign clr_any = shdn || por_wr || fault_rst_wr || !bat_min_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fault_q <= 1'b0;
    else if (clr_any)    fault_q <= 1'b0;
    else if (cutoff_evt) fault_q <= 1'b1;
  end

  assign fault_n = !(gpio2_fault_sel && fault_q && !dcin_uv);

  AST_FAULT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn || por_wr || fault_rst_wr) |=> !fault_q); // R8
  AST_FAULT_LOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_min_ok |=> !fault_q); // R7
  AST_FAULT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(cutoff_evt)); // R4
endmodule

// File: rtl/bkup_acp_delay.sv
module bkup_acp_delay #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  output logic acp_n
);
  localparam int            CW   = (DELAY < 1) ? 1 : $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);

  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= LOAD;
      acp_n <= 1'b1;
    end else if (!present) begin
      cnt   <= LOAD;
      acp_n <= 1'b1;
    end else if (cnt_zero) begin
      acp_n <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_ACP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> acp_n); // R10
  AST_ACP_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acp_n) |-> $past(present)); // R10
endmodule

// File: rtl/bkup_path_ctrl.sv
module bkup_path_ctrl
  import bkup_pkg::*;
#(
  parameter int ACP_DELAY   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_ok_a,
  input  logic dcin_uv_a,
  input  logic dcout_uv_a,
  input  logic bat_low_a,
  input  logic bat_min_ok_a,
  input  logic shdn_a,
  input  logic por_wr,
  input  logic fault_rst_wr,
  input  logic gpio2_fault_sel,
  output logic in_sw_enable,
  output logic bat_sw_enable,
  output logic flyback_enable,
  output logic bkup_fault,
  output logic bkfault_n,
  output logic acp_n
);
  localparam logic [N_IN-1:0] SYNC_RST = 6'b011010;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] syn_in;
  mode_e           mode;
  drv_t            drv;
  logic            cutoff_evt;
  logic            present;

  assign raw_in = {sup_ok_a, dcin_uv_a, dcout_uv_a, bat_low_a, bat_min_ok_a, shdn_a};

  bkup_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_a   (raw_in),
    .q     (syn_in)
  );

  bkup_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_ok     (syn_in[IX_SUP]),
    .dcin_uv    (syn_in[IX_DCIN]),
    .dcout_uv   (syn_in[IX_DCOUT]),
    .bat_low    (syn_in[IX_BLOW]),
    .shdn       (syn_in[IX_SHDN]),
    .mode       (mode),
    .drv        (drv),
    .cutoff_evt (cutoff_evt)
  );

  bkup_fault_latch u_fault (
    .clk             (clk),
    .rst_n           (rst_n),
    .cutoff_evt      (cutoff_evt),
    .shdn            (syn_in[IX_SHDN]),
    .por_wr          (por_wr),
    .fault_rst_wr    (fault_rst_wr),
    .bat_min_ok      (syn_in[IX_BMIN]),
    .dcin_uv         (syn_in[IX_DCIN]),
    .gpio2_fault_sel (gpio2_fault_sel),
    .fault_q         (bkup_fault),
    .fault_n         (bkfault_n)
  );

  assign present = supply_present(syn_in[IX_SUP], syn_in[IX_DCIN]);

  bkup_acp_delay #(.DELAY(ACP_DELAY)) u_acp (
    .clk     (clk),
    .rst_n   (rst_n),
    .present (present),
    .acp_n   (acp_n)
  );

  assign in_sw_enable   = drv.in_sw;
  assign bat_sw_enable  = drv.bat_sw;
  assign flyback_enable = drv.fly;

  AST_BKUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_MAIN && need_backup(syn_in[IX_SUP], syn_in[IX_DCIN], syn_in[IX_DCOUT])
     && !syn_in[IX_SHDN]) |=> !in_sw_enable); // R1
  AST_HOLD_NO_BAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_HOLD) |=> !bat_sw_enable); // R5
endmodule

// File: tb/bkup_path_ctrl_test.sv
module bkup_path_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_ok_a = 1'b1, dcin_uv_a = 1'b0, dcout_uv_a = 1'b0;
  logic bat_low_a = 1'b0, bat_min_ok_a = 1'b1, shdn_a = 1'b0;
  logic por_wr = 1'b0, fault_rst_wr = 1'b0, gpio2_fault_sel = 1'b1;
  logic in_sw_enable, bat_sw_enable, flyback_enable, bkup_fault, bkfault_n, acp_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bkup_path_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .sup_ok_a(sup_ok_a), .dcin_uv_a(dcin_uv_a), .dcout_uv_a(dcout_uv_a),
    .bat_low_a(bat_low_a), .bat_min_ok_a(bat_min_ok_a), .shdn_a(shdn_a),
    .por_wr(por_wr), .fault_rst_wr(fault_rst_wr), .gpio2_fault_sel(gpio2_fault_sel),
    .in_sw_enable(in_sw_enable), .bat_sw_enable(bat_sw_enable),
    .flyback_enable(flyback_enable), .bkup_fault(bkup_fault),
    .bkfault_n(bkfault_n), .acp_n(acp_n)
  );

  // {sup_ok, dcin_uv, dcout_uv, bat_low, bat_min_ok} -> {in_sw, bat_sw, fly}
  localparam int NV = 7;
  localparam logic [7:0] VEC [NV] = '{
    8'b10001_101,
    8'b00001_010,
    8'b10001_101,
    8'b11001_010,
    8'b10001_101,
    8'b10101_010,
    8'b10001_101
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_path(input string tag, input logic e_in, input logic e_bat, input logic e_fly);
    chk({tag, " in_sw"},  in_sw_enable,   e_in);
    chk({tag, " bat_sw"}, bat_sw_enable,  e_bat);
    chk({tag, " fly"},    flyback_enable, e_fly);
  endtask

  // both path switches closed at once is never legal
  always @(negedge clk) begin
    if (rst_n && in_sw_enable && bat_sw_enable) begin
      n_bad++;
      $display("FAIL R3: in_sw=1 bat_sw=1 expected not both at %0t", $time);
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    step(3);
    chk_path("R12", 1'b0, 1'b0, 1'b0);
    chk("R12 acp_n", acp_n, 1'b1);
    chk("R12 fault", bkup_fault, 1'b0);
    chk("R12 fault_n", bkfault_n, 1'b1);
    rst_n = 1'b1;
    step(20);

    // table walk: R1 entry / R2 return
    for (int i = 0; i < NV; i++) begin
      {sup_ok_a, dcin_uv_a, dcout_uv_a, bat_low_a, bat_min_ok_a} = VEC[i][7:3];
      step(6);
      chk_path($sformatf("R1 R2 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R3 changeover gap: supply loss from main
    sup_ok_a = 1'b0;
    step(3);
    chk_path("R3 gap to bkup", 1'b0, 1'b0, 1'b0);
    step(1);
    chk_path("R3 bkup after gap", 1'b0, 1'b1, 1'b0);
    sup_ok_a = 1'b1;
    step(3);
    chk_path("R3 gap to main", 1'b0, 1'b0, 1'b0);
    step(1);
    chk_path("R3 main after gap", 1'b1, 1'b0, 1'b1);

    // R4/R5 cutoff with input rail healthy
    sup_ok_a = 1'b0;
    step(6);
    bat_low_a = 1'b1;
    step(2);
    chk("R4 bat before cutoff", bat_sw_enable, 1'b1);
    chk("R4 fault before cutoff", bkup_fault, 1'b0);
    step(1);
    chk_path("R4 cutoff open", 1'b0, 1'b0, 1'b0);
    chk("R4 fault set", bkup_fault, 1'b1);
    step(1);
    chk_path("R5 hold on input", 1'b1, 1'b0, 1'b0);
    bat_low_a = 1'b0;
    step(6);
    chk_path("R5 no reconnect", 1'b1, 1'b0, 1'b0);
    chk("R9 fault_n low", bkfault_n, 1'b0);
    gpio2_fault_sel = 1'b0;
    step(1);
    chk("R9 fault_n deselected", bkfault_n, 1'b1);
    gpio2_fault_sel = 1'b1;
    sup_ok_a = 1'b1;
    step(6);
    chk_path("R5 back to main", 1'b1, 1'b0, 1'b1);
    chk("R7 fault kept", bkup_fault, 1'b1);
    fault_rst_wr = 1'b1;
    step(1);
    fault_rst_wr = 1'b0;
    chk("R8 fault_rst_wr clears", bkup_fault, 1'b0);

    // R6 cutoff with input rail down -> shutdown, auto exit
    dcin_uv_a = 1'b1;
    step(6);
    chk_path("R1 uv backup", 1'b0, 1'b1, 1'b0);
    bat_low_a = 1'b1;
    step(6);
    chk_path("R6 shutdown", 1'b0, 1'b0, 1'b0);
    chk("R6 fault set", bkup_fault, 1'b1);
    chk("R9 fault_n high while uv", bkfault_n, 1'b1);
    bat_low_a = 1'b0;
    dcin_uv_a = 1'b0;
    step(6);
    chk_path("R6 shutdown exit", 1'b1, 1'b0, 1'b1);
    chk("R7 fault survives rail return", bkup_fault, 1'b1);
    chk("R9 fault_n after return", bkfault_n, 1'b0);
    por_wr = 1'b1;
    step(1);
    por_wr = 1'b0;
    chk("R8 por_wr clears", bkup_fault, 1'b0);

    // R8 shutdown pin clears
    sup_ok_a = 1'b0; step(6); bat_low_a = 1'b1; step(6);
    bat_low_a = 1'b0; sup_ok_a = 1'b1; step(8);
    chk("R8 fault re-set", bkup_fault, 1'b1);
    shdn_a = 1'b1;
    step(2);
    chk("R8 shdn not yet", bkup_fault, 1'b1);
    step(1);
    chk("R8 shdn clears", bkup_fault, 1'b0);
    shdn_a = 1'b0;
    step(4);

    // R7 battery below minimum clears
    sup_ok_a = 1'b0; step(6); bat_low_a = 1'b1; step(6);
    bat_low_a = 1'b0; sup_ok_a = 1'b1; step(8);
    chk("R7 fault re-set", bkup_fault, 1'b1);
    bat_min_ok_a = 1'b0;
    step(3);
    chk("R7 bat min clears", bkup_fault, 1'b0);
    bat_min_ok_a = 1'b1;
    step(4);

    // R10 supply-present status
    chk("R10 acp_n low steady", acp_n, 1'b0);
    sup_ok_a = 1'b0;
    step(2);
    chk("R10 acp_n still low", acp_n, 1'b0);
    step(1);
    chk("R10 acp_n released", acp_n, 1'b1);
    step(20);
    sup_ok_a = 1'b1;
    step(10);
    chk("R10 acp_n delayed", acp_n, 1'b1);
    step(1);
    chk("R10 acp_n asserted", acp_n, 1'b0);
    dcin_uv_a = 1'b1;
    step(3);
    chk("R10 acp_n uv release", acp_n, 1'b1);
    dcin_uv_a = 1'b0;
    step(20);

    // R11 forced shutdown
    dcin_uv_a = 1'b1;
    step(6);
    chk_path("R11 pre backup", 1'b0, 1'b1, 1'b0);
    shdn_a = 1'b1;
    step(6);
    chk_path("R11 forced off", 1'b0, 1'b0, 1'b0);
    dcin_uv_a = 1'b0;
    step(6);
    chk_path("R11 exit on rail return", 1'b1, 1'b0, 1'b1);
    shdn_a = 1'b0;
    step(4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule